// File: doc/BRIEF.md
# Address-Framed Serial Control Port for a Key-Scanning Display Controller

This block is the slave side of a three-wire synchronous serial link with an open-drain return line. A host selects the port by clocking in an 8-bit address while the enable line is low. It then raises enable and either writes one half of the 48-bit segment image or reads the key matrix state. A write half also carries the mode and control fields, and its last two bits say which half it is. A read returns 20 key bits followed by a flag that reports whether sleep is selected.

All pins are sampled in the system clock domain through a synchronizer, so the link clock may idle low or high. Data is taken on each rising link-clock edge. The read shifter moves on each falling edge that follows a rising edge in the same frame. Bits go out least significant first.

After reset the block stays in a hold state, and `hold_o` tells the display and scan logic to stay blank and idle. Frames are still accepted during hold. Hold ends on the enable fall that completes the second distinct half of the image. While enable is low and hold is clear, the return line is pulled low whenever the scanner asks for a key read, so the same wire works as an interrupt.

Top module: `panel_ser_port`

## Requirements
- R1: While `hold_o` is 1, `sdo_o` reads 1 whatever `key_req_i` or the frame type. After `rst_n` is released, `hold_o` is 1.
- R2: A frame addressed 42h with exactly 35 data bits is latched on enable fall. Bits 0..23 are segment data, bits 24..32 are control, and bits 33..34 are the direction code. Control bits in order: sleep[1:0], pin[1:0], port[2:0], blank, bias. Direction 00 loads `disp_o[23:0]` and the control outputs. Direction 01 loads `disp_o[47:24]` only, and its control bits have no effect.
- R3: Frames are latched during hold. `hold_o` falls on the enable fall that latches the second distinct half, in either order, and stays 0 until the next reset.
- R4: A 42h frame with any other bit count, or with direction code 10 or 11, changes no output.
- R5: A frame whose address is neither 42h nor 43h changes no register, and `sdo_o` stays 1 while enable is high.
- R6: With enable low and hold clear, `sdo_o` equals the inverse of `key_req_i`.
- R7: In a 43h frame, `sdo_o` gives `key_i[0]` after enable rises. It advances one bit on each falling clock edge that follows a rising edge in that frame. Bit 20 is 1 when either sleep bit is set. Later bits read 1.
- R8: Write and read frames give identical results whether the clock idles low or high.
- R9: In hold, a read frame returns all ones and gives no `read_done_o` pulse.
- R10: `read_done_o` is a one-cycle pulse after the enable fall that ends a 43h frame with hold clear.
- R11: While enable is high in a non-read frame, `sdo_o` is 1 even if `key_req_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (supply-fault reset) |
| ce_i | input | 1 | Link enable, asynchronous |
| sck_i | input | 1 | Link clock, asynchronous |
| sdi_i | input | 1 | Link data in |
| sdo_o | output | 1 | Open-drain data out / read request, 0 = pulled low |
| key_i | input | 20 | Debounced key matrix bits from the scanner |
| key_req_i | input | 1 | Scanner asks for a key read |
| read_done_o | output | 1 | Key read finished, clears the scanner request |
| hold_o | output | 1 | Display and scan held off |
| disp_o | output | 48 | Segment image |
| sleep_o | output | 2 | Sleep selection field |
| pin_o | output | 2 | Shared-pin function field |
| port_o | output | 3 | Segment/general-output selection field |
| blank_o | output | 1 | Blank all segments |
| bias_o | output | 1 | Bias scheme select |

## Verification
The assertions assume that enable never changes in the same synchronized cycle as a link-clock edge. They also assume each link-clock level lasts longer than the synchronizer delay, so every rise and fall is seen once and in order. The bench holds each link level for 12 system cycles and moves enable only half a bit period away from any clock edge. It draws frame contents, key patterns, control values and the clock idle level at random, and adds directed short, long, misdirected and misaddressed frames.

// File: rtl/pserp_pkg.sv
// Shared constants and types for the serial control port.
// Assumes the frame layout: segment half, control field, direction code.
package pserp_pkg;
    localparam int CTRL_W = 9;
    localparam int DIR_W  = 2;

    localparam logic [DIR_W-1:0] DIR_LOW  = 2'b00;
    localparam logic [DIR_W-1:0] DIR_HIGH = 2'b01;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_WRITE = 2'd1,
        FR_READ  = 2'd2,
        FR_SKIP  = 2'd3
    } frame_kind_e;

    // First received control bit lands in sleep[0].
    typedef struct packed {
        logic       bias;
        logic       blank;
        logic [2:0] port;
        logic [1:0] pin;
        logic [1:0] sleep;
    } ctrl_t;
endpackage

// File: rtl/pserp_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins.
// Assumes each pin is a level that stays put longer than STAGES cycles.
module pserp_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] chain;

    // Shift the pin group through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/pserp_frame_rx.sv
// Address capture, frame-type decode and write shift register.
// Assumes synchronized pins and that enable and clock edges never coincide.
// The write shift register has no reset: its contents are qualified by the
// bit counter.
module pserp_frame_rx
    import pserp_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] WR_ADDR = 8'h42,
    parameter logic [ADDR_W-1:0] RD_ADDR = 8'h43,
    parameter int                FRAME_W = 35
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_lvl,
    input  logic               ce_rise,
    input  logic               ce_fall,
    input  logic               sck_rise,
    input  logic               sdi,
    output frame_kind_e        kind_o,
    output logic               rd_start_o,
    output logic               full_o,
    output logic [FRAME_W-1:0] sr_o
);
    localparam int CW = $clog2(FRAME_W + 2);

    logic [ADDR_W-1:0]  addr_q;
    logic [CW-1:0]      cnt_q;
    logic [FRAME_W-1:0] sr_q;
    frame_kind_e        kind_q;
    logic               wr_bit;

    assign wr_bit = (kind_q == FR_WRITE) && ce_lvl && sck_rise;

    // Keep the last ADDR_W bits seen while enable is low, first bit in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!ce_lvl && sck_rise) begin
            addr_q <= {sdi, addr_q[ADDR_W-1:1]};
        end
    end

    // Decode the frame type when enable rises, drop it when enable falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= FR_IDLE;
        end else if (ce_rise) begin
            if (addr_q == WR_ADDR)      kind_q <= FR_WRITE;
            else if (addr_q == RD_ADDR) kind_q <= FR_READ;
            else                        kind_q <= FR_SKIP;
        end else if (ce_fall) begin
            kind_q <= FR_IDLE;
        end
    end

    // Count write data bits, saturating one past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ce_rise) begin
            cnt_q <= '0;
        end else if (wr_bit && cnt_q != CW'(FRAME_W + 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Shift write data in, first bit ending up in bit 0.
    always_ff @(posedge clk) begin
        if (wr_bit) begin
            sr_q <= {sdi, sr_q[FRAME_W-1:1]};
        end
    end

    assign kind_o     = kind_q;
    assign rd_start_o = ce_rise && (addr_q == RD_ADDR);
    assign full_o     = (cnt_q == CW'(FRAME_W));
    assign sr_o       = sr_q;
endmodule

// File: rtl/pserp_key_tx.sv
// Read-frame shifter: loads key bits plus sleep flag, shifts on falling
// clock edges that follow a rising edge within the frame, fills with ones.
// Assumes load and shift requests never arrive in the same cycle.
module pserp_key_tx #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         active_i,
    input  logic         sck_rise,
    input  logic         sck_fall,
    output logic         bit_o
);
    logic [W-1:0] tx_q;
    logic         seen_q;

    // Load at frame start, then move one bit per qualified falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '1;
            seen_q <= 1'b0;
        end else if (load_i) begin
            tx_q   <= data_i;
            seen_q <= 1'b0;
        end else if (active_i) begin
            if (sck_rise) begin
                seen_q <= 1'b1;
            end
            if (sck_fall && seen_q) begin
                tx_q <= {1'b1, tx_q[W-1:1]};
            end
        end
    end

    assign bit_o = tx_q[0];
endmodule

// File: rtl/panel_ser_port.sv
// Serial control port top: synchronizes the link pins, latches the two
// display halves and the control field, and runs the hold state and the
// shared data-out / request line.
// Assumes a system clock well above the link clock. The display and control
// registers have no reset, matching a port that must accept data at any time.
module panel_ser_port
    import pserp_pkg::*;
#(
    parameter int                DISP_W      = 48,
    parameter int                KEY_W       = 20,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] WR_ADDR     = 8'h42,
    parameter logic [ADDR_W-1:0] RD_ADDR     = 8'h43,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              key_req_i,
    output logic              read_done_o,
    output logic              hold_o,
    output logic [DISP_W-1:0] disp_o,
    output logic [1:0]        sleep_o,
    output logic [1:0]        pin_o,
    output logic [2:0]        port_o,
    output logic              blank_o,
    output logic              bias_o
);
    localparam int HALF    = DISP_W / 2;
    localparam int FRAME_W = HALF + CTRL_W + DIR_W;
    localparam int TX_W    = KEY_W + 1;

    logic               ce_s, sck_s, sdi_s, ce_p, sck_p;
    logic               ce_rise, ce_fall, sck_rise, sck_fall;
    frame_kind_e        kind;
    logic               rd_start, full, rd_act, tx_bit, wr_end, lat_any;
    logic [FRAME_W-1:0] sr;
    logic [DIR_W-1:0]   dir;
    logic [1:0]         lat, got_q;
    logic               hold_q, sdo_q, done_q;
    ctrl_t              ctrl_q;

    pserp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sck_i, ce_i}),
        .sync_o  ({sdi_s, sck_s, ce_s})
    );

    // Remember the previous synchronized enable and clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_p  <= 1'b0;
            sck_p <= 1'b0;
        end else begin
            ce_p  <= ce_s;
            sck_p <= sck_s;
        end
    end

    assign ce_rise  = ce_s && !ce_p;
    assign ce_fall  = !ce_s && ce_p;
    assign sck_rise = sck_s && !sck_p;
    assign sck_fall = !sck_s && sck_p;

    pserp_frame_rx #(
        .ADDR_W (ADDR_W), .WR_ADDR (WR_ADDR), .RD_ADDR (RD_ADDR), .FRAME_W (FRAME_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_lvl     (ce_s),
        .ce_rise    (ce_rise),
        .ce_fall    (ce_fall),
        .sck_rise   (sck_rise),
        .sdi        (sdi_s),
        .kind_o     (kind),
        .rd_start_o (rd_start),
        .full_o     (full),
        .sr_o       (sr)
    );

    assign rd_act = (kind == FR_READ) && ce_s;

    pserp_key_tx #(.W(TX_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (rd_start),
        .data_i   ({|ctrl_q.sleep, key_i}),
        .active_i (rd_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .bit_o    (tx_bit)
    );

    // Latch strobes: a complete write frame with a known direction code.
    assign dir     = sr[FRAME_W-1 -: DIR_W];
    assign wr_end  = ce_fall && (kind == FR_WRITE) && full;
    assign lat[0]  = wr_end && (dir == DIR_LOW);
    assign lat[1]  = wr_end && (dir == DIR_HIGH);
    assign lat_any = |lat;

    // One register per display half, each loaded by its own strobe.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF-1:0] q;
        always_ff @(posedge clk) begin
            if (lat[h]) begin
                q <= sr[HALF-1:0];
            end
        end
        assign disp_o[h*HALF +: HALF] = q;
    end

    // Control field travels only with the lower half.
    always_ff @(posedge clk) begin
        if (lat[0]) begin
            ctrl_q <= ctrl_t'(sr[HALF +: CTRL_W]);
        end
    end

    // Hold until both halves have been latched since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_q  <= 2'b00;
            hold_q <= 1'b1;
        end else begin
            got_q <= got_q | lat;
            if (lat_any && (&(got_q | lat))) begin
                hold_q <= 1'b0;
            end
        end
    end

    // Shared return line: read data in read frames, request when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b1;
        end else if (hold_q) begin
            sdo_q <= 1'b1;
        end else if (ce_s) begin
            sdo_q <= rd_act ? tx_bit : 1'b1;
        end else begin
            sdo_q <= !key_req_i;
        end
    end

    // Report the end of a key read outside hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= ce_fall && (kind == FR_READ) && !hold_q;
        end
    end

    assign sdo_o       = sdo_q;
    assign read_done_o = done_q;
    assign hold_o      = hold_q;
    assign sleep_o     = ctrl_q.sleep;
    assign pin_o       = ctrl_q.pin;
    assign port_o      = ctrl_q.port;
    assign blank_o     = ctrl_q.blank;
    assign bias_o      = ctrl_q.bias;
endmodule

// File: rtl/panel_ser_port_chk.sv
// Temporal checks on the serial control port, attached by bind.
// Assumes rst_n is the same synchronous reset the port uses.
module panel_ser_port_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_o,
    input logic sdo_o,
    input logic read_done_o,
    input logic key_req_i,
    input logic rd_act,
    input logic lat_any
);
    a_r1_hold_keeps_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> sdo_o);

    a_r3_hold_never_returns: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |=> !hold_o);

    a_r3_release_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> $past(lat_any));

    a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |=> !read_done_o);

    a_r9_done_outside_hold: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |-> !hold_o);

    a_r6_low_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_o |-> $past(key_req_i || rd_act));
endmodule

bind panel_ser_port panel_ser_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_o      (hold_o),
    .sdo_o       (sdo_o),
    .read_done_o (read_done_o),
    .key_req_i   (key_req_i),
    .rd_act      (rd_act),
    .lat_any     (lat_any)
);

// File: tb/panel_ser_port_test.sv
module panel_ser_port_test;
    localparam int HP = 12;

    logic        clk = 1'b0;
    logic        rst_n, ce, sck, sdi, key_req;
    logic [19:0] keys;
    logic        sdo, done, hold, blank, bias;
    logic [47:0] disp;
    logic [1:0]  sleep, pin;
    logic [2:0]  port;

    int          n_chk = 0, n_fail = 0, done_cnt = 0;
    logic [47:0] exp_disp;
    logic [8:0]  exp_ctrl;
    logic [1:0]  exp_got;
    logic        exp_hold;
    logic        mid;
    logic [31:0] got;

    always #2 clk = ~clk;

    panel_ser_port uut (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
        .key_i(keys), .key_req_i(key_req), .read_done_o(done), .hold_o(hold),
        .disp_o(disp), .sleep_o(sleep), .pin_o(pin), .port_o(port),
        .blank_o(blank), .bias_o(bias)
    );

    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b, input logic ih);
        if (ih) begin
            sck = 1'b0; sdi = b; wait_cyc(HP); sck = 1'b1; wait_cyc(HP);
        end else begin
            sdi = b; wait_cyc(HP); sck = 1'b1; wait_cyc(HP); sck = 1'b0;
        end
    endtask

    task automatic send_addr(input logic [7:0] a, input logic ih);
        ce = 1'b0; sck = ih; wait_cyc(HP);
        for (int i = 0; i < 8; i++) send_bit(a[i], ih);
        wait_cyc(HP); ce = 1'b1; wait_cyc(HP);
    endtask

    task automatic write_frame(input logic [7:0] a, input logic [63:0] v, input int n,
                               input logic ih);
        send_addr(a, ih);
        for (int i = 0; i < n; i++) begin
            send_bit(v[i], ih);
            if (i == 10) mid = sdo;
        end
        wait_cyc(HP); ce = 1'b0; wait_cyc(2*HP);
    endtask

    task automatic read_frame(input logic ih, input int n);
        got = '1;
        send_addr(8'h43, ih);
        for (int i = 0; i < n; i++) begin
            if (ih) begin
                sck = 1'b0; wait_cyc(HP); got[i] = sdo; sck = 1'b1; wait_cyc(HP);
            end else begin
                got[i] = sdo; sck = 1'b1; wait_cyc(HP); sck = 1'b0; wait_cyc(HP);
            end
        end
        ce = 1'b0; wait_cyc(2*HP);
    endtask

    function automatic logic [63:0] make_frame(input logic [23:0] d, input logic [8:0] c,
                                               input logic [1:0] dir);
        return {29'b0, dir[1], dir[0], c, d};
    endfunction

    function automatic logic [22:0] exp_read(input logic [19:0] k, input logic [8:0] c);
        return {2'b11, |c[1:0], k};
    endfunction

    // Reference update for a complete, correctly tagged write frame.
    task automatic model_write(input logic [23:0] d, input logic [8:0] c, input logic hi);
        if (hi) begin
            exp_disp[47:24] = d; exp_got[1] = 1'b1;
        end else begin
            exp_disp[23:0] = d; exp_ctrl = c; exp_got[0] = 1'b1;
        end
        if (&exp_got) exp_hold = 1'b0;
    endtask

    task automatic check_regs(input string req);
        check({req, " disp"}, {16'b0, disp}, {16'b0, exp_disp});
        check({req, " ctrl"}, {55'b0, bias, blank, port, pin, sleep}, {55'b0, exp_ctrl});
        check({req, " hold"}, {63'b0, hold}, {63'b0, exp_hold});
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [23:0] d;
        logic [8:0]  c;
        int          base;
        void'($urandom(32'd2024));
        rst_n = 1'b0; ce = 1'b0; sck = 1'b0; sdi = 1'b0; key_req = 1'b0; keys = '0;
        exp_got = 2'b00; exp_hold = 1'b1; exp_disp = '0; exp_ctrl = '0;
        wait_cyc(5); rst_n = 1'b1; wait_cyc(5);
        check("R1 hold after reset", {63'b0, hold}, 64'd1);
        check("R1 line high after reset", {63'b0, sdo}, 64'd1);

        // R9: request and read during hold
        key_req = 1'b1; keys = 20'h5A5A5; wait_cyc(HP);
        check("R9 request masked in hold", {63'b0, sdo}, 64'd1);
        base = done_cnt;
        read_frame(1'b0, 23);
        check("R9 read in hold all ones", {41'b0, got[22:0]}, {41'b0, 23'h7FFFFF});
        check("R9 no done in hold", base, done_cnt);

        // R2/R3: lower half during hold, then upper half releases hold
        d = 24'($urandom); c = 9'h000;
        write_frame(8'h42, make_frame(d, c, 2'b00), 35, 1'b0);
        model_write(d, c, 1'b0);
        exp_disp[47:24] = disp[47:24];
        check_regs("R3 lower half in hold");
        d = 24'($urandom);
        write_frame(8'h42, make_frame(d, 9'h1FF, 2'b01), 35, 1'b0);
        model_write(d, 9'h1FF, 1'b1);
        check_regs("R2 R3 upper half releases hold");

        // R6: request line when idle
        key_req = 1'b1; wait_cyc(HP);
        check("R6 request pulls low", {63'b0, sdo}, 64'd0);
        key_req = 1'b0; wait_cyc(HP);
        check("R6 no request high", {63'b0, sdo}, 64'd1);

        // R7/R10: read with clock idle low
        keys = 20'($urandom); base = done_cnt;
        read_frame(1'b0, 23);
        check("R7 read idle low", {41'b0, got[22:0]}, {41'b0, exp_read(keys, exp_ctrl)});
        check("R10 done pulse", done_cnt, base + 1);

        // R11/R2: control update with request pending during the frame
        key_req = 1'b1;
        d = 24'($urandom); c = 9'h0A2;
        write_frame(8'h42, make_frame(d, c, 2'b00), 35, 1'b0);
        check("R11 line high inside write", {63'b0, mid}, 64'd1);
        model_write(d, c, 1'b0);
        check_regs("R2 control update");
        key_req = 1'b0;

        // R8/R7: idle-high read with sleep flag set, idle-high write
        keys = 20'($urandom);
        read_frame(1'b1, 23);
        check("R8 R7 read idle high", {41'b0, got[22:0]}, {41'b0, exp_read(keys, exp_ctrl)});
        d = 24'($urandom); c = 9'($urandom);
        write_frame(8'h42, make_frame(d, c, 2'b00), 35, 1'b1);
        model_write(d, c, 1'b0);
        check_regs("R8 write idle high");

        // R4: wrong length and unknown direction codes
        write_frame(8'h42, make_frame(~exp_disp[23:0], ~exp_ctrl, 2'b00), 34, 1'b0);
        check_regs("R4 short frame ignored");
        write_frame(8'h42, make_frame(~exp_disp[23:0], ~exp_ctrl, 2'b00), 36, 1'b1);
        check_regs("R4 long frame ignored");
        write_frame(8'h42, make_frame(~exp_disp[23:0], ~exp_ctrl, 2'b10), 35, 1'b0);
        check_regs("R4 direction 10 ignored");
        write_frame(8'h42, make_frame(~exp_disp[23:0], ~exp_ctrl, 2'b11), 35, 1'b0);
        check_regs("R4 direction 11 ignored");

        // R5: unknown address
        key_req = 1'b1;
        write_frame(8'h55, make_frame(~exp_disp[23:0], ~exp_ctrl, 2'b00), 35, 1'b0);
        check("R5 line high in foreign frame", {63'b0, mid}, 64'd1);
        check_regs("R5 foreign frame ignored");
        key_req = 1'b0;

        // Random mix of writes and reads
        for (int it = 0; it < 18; it++) begin
            logic ih;
            int   op;
            ih = 1'($urandom);
            op = int'($urandom % 3);
            d = 24'($urandom); c = 9'($urandom);
            if (op == 2) begin
                keys = 20'($urandom); base = done_cnt;
                read_frame(ih, 23);
                check("R7 random read", {41'b0, got[22:0]}, {41'b0, exp_read(keys, exp_ctrl)});
                check("R10 random done", done_cnt, base + 1);
            end else begin
                write_frame(8'h42, make_frame(d, c, op[0] ? 2'b01 : 2'b00), 35, ih);
                model_write(d, c, op[0]);
                check_regs("R2 random write");
            end
        end

        // R1/R3: reset again, upper half first this time
        rst_n = 1'b0; wait_cyc(3); rst_n = 1'b1; key_req = 1'b1; wait_cyc(5);
        exp_got = 2'b00; exp_hold = 1'b1;
        check("R1 hold after second reset", {63'b0, hold}, 64'd1);
        check("R1 line high with request in hold", {63'b0, sdo}, 64'd1);
        d = 24'($urandom);
        write_frame(8'h42, make_frame(d, 9'h000, 2'b01), 35, 1'b1);
        model_write(d, 9'h000, 1'b1);
        check("R3 hold after one half", {63'b0, hold}, 64'd1);
        d = 24'($urandom); c = 9'($urandom);
        write_frame(8'h42, make_frame(d, c, 2'b00), 35, 1'b0);
        model_write(d, c, 1'b0);
        check_regs("R3 hold released upper first");
        wait_cyc(HP);
        check("R6 request after release", {63'b0, sdo}, 64'd0);
        key_req = 1'b0;
        summary();
    end
endmodule